// File: doc/BRIEF.md
# Floppy Controller Command/Result Phase Sequencer

This block sits behind the host data port of a floppy disk controller and walks every command through its phases. The host writes an opcode byte; the sequencer looks up how many parameter bytes follow, collects them, and then does one of three things. It may hand the command to an execution engine and wait for its completion pulse. It may move straight to a result phase and present status bytes for the host to read. It may return to idle when the command has no result. Unknown opcodes get an immediate invalid-command answer. A main status byte tells the host at every moment whether a byte may be moved and in which direction, whether a command is in progress, whether execution is running in non-DMA mode, and which drives still have a seek outstanding.

The host side is two byte streams. Command bytes enter on a valid/ready pair. The host keeps `host_wr_valid` and `host_wr_data` steady until it sees `host_wr_ready`, and a byte is taken on a rising edge where both are high. Result bytes leave on a valid/ready pair under the same rule. Ready and valid from the block depend only on its state, never on the host's valid or ready in the same cycle. The execution engine is a stub: it receives a start pulse with the opcode and answers with `exec_done` and up to three status bytes. The present-track values for the sense-interrupt answer come in on plain inputs.

Top module: `fdc_phase_seq`

## Requirements
- R1: After reset is released the status byte reads 00h for INIT_CYCLES rising edges. It reads 80h from the INIT_CYCLES-th edge on, and no byte is accepted or offered before that.
- R2: Request-for-master (status bit 7) drops in the cycle after any byte is accepted or read, and it returns one cycle later when another byte may move. `host_wr_ready` is high only when bit 7 is 1 and bit 6 is 0. `host_rd_valid` is high only when bit 7 is 1 and bit 6 is 1.
- R3: The status byte has this layout: bit 7 request-for-master, bit 6 direction (1 = result bytes to read), bit 5 non-DMA execution (execution phase with `nondma_mode` high), bit 4 command busy, bits 3..0 drive seek busy with drive n on bit n.
- R4: Command busy sets with the first command byte. It clears with the last result byte read, or with the last command byte when the command has no result.
- R5: Only opcode bits 4..0 are decoded. Each entry gives bytes including the opcode / result bytes: 03h 3/0, 04h 2/1 (executed), 06h 9/7 (executed), 07h 2/0, 08h 1/2, 0Fh 3/0, 13h 4/0, 18h 1/1.
- R6: With `ext_track_en` high, opcode 0Fh takes 4 bytes and opcode 08h returns 3 bytes.
- R7: Any opcode whose bits 4..0 are not in the table moves straight to the result phase with the single byte 80h, and command busy is set.
- R8: Opcode 18h returns the single byte 73h.
- R9: The last command byte of 07h or 0Fh sets the busy bit of the drive in bits 1..0 of the second command byte. Reading the first result byte of 08h clears the busy bit of the drive in bits 1..0 of that byte.
- R10: For executed opcodes the last command byte starts the execution phase. `exec_start` is high for one cycle, and during that cycle `exec_opcode` carries opcode bits 4..0. On `exec_done` the result phase opens. For 04h the result is `exec_st0`. For 06h the result is `exec_st0`, `exec_st1`, `exec_st2`, then command bytes 2, 3, 4 and 5.
- R11: The 08h answer is `sense_st0`, `sense_pcn` and (under R6) `sense_pcn_hi`, sampled on the edge that accepts the opcode.
- R12: Write attempts while direction is 1, read attempts while direction is 0, and `exec_done` outside the execution phase change nothing in the status byte or in the bytes later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_track_en | input | 1 | Enables the extra upper-track byte for seek and sense interrupt |
| nondma_mode | input | 1 | Execution runs without DMA; shown on status bit 5 |
| host_wr_valid | input | 1 | Host offers a command byte |
| host_wr_ready | output | 1 | Sequencer takes a command byte |
| host_wr_data | input | 8 | Command byte |
| host_rd_valid | output | 1 | Result byte offered |
| host_rd_ready | input | 1 | Host takes the result byte |
| host_rd_data | output | 8 | Result byte |
| msr | output | 8 | Main status byte |
| exec_start | output | 1 | One-cycle start pulse to the execution engine |
| exec_opcode | output | 5 | Decoded opcode for the engine |
| exec_done | input | 1 | Engine finished |
| exec_st0 | input | 8 | Engine status byte 0 |
| exec_st1 | input | 8 | Engine status byte 1 |
| exec_st2 | input | 8 | Engine status byte 2 |
| sense_st0 | input | 8 | Status 0 for the sense-interrupt answer |
| sense_pcn | input | 8 | Present track for the sense-interrupt answer |
| sense_pcn_hi | input | 8 | Upper track nibble byte for the sense-interrupt answer |

## Verification
Every accepted or read byte shows in the status byte on the next edge, with request-for-master low. Request-for-master returns one edge later, so the bench drives on falling edges, reads the status at the falling edge that ends the transfer and again one falling edge later. The execution start pulse and the busy-bit changes also appear one edge after the transfer that causes them, and they are sampled at that same falling edge. The power-up window is counted edge by edge: the status is checked as 00h after INIT_CYCLES-1 edges and as 80h after INIT_CYCLES edges.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  localparam int MAX_CMD_BYTES = 9;
  localparam int MAX_RES_BYTES = 7;
  localparam int NUM_DRIVES    = 4;
  localparam int CIDX_W        = $clog2(MAX_CMD_BYTES + 1);
  localparam int RIDX_W        = $clog2(MAX_RES_BYTES + 1);
  localparam int RES_SLOTS     = 1 << RIDX_W;
  localparam int DRV_W         = $clog2(NUM_DRIVES);
  // command bytes kept for echo in results: drive/head byte up to sector size
  localparam int KEEP_LO       = 1;
  localparam int KEEP_HI       = 5;

  typedef enum logic [1:0] {PH_INIT, PH_CMD, PH_EXEC, PH_RES} phase_t;

  localparam logic [4:0] OP_SPECIFY   = 5'h03;
  localparam logic [4:0] OP_SENSE_DRV = 5'h04;
  localparam logic [4:0] OP_READ      = 5'h06;
  localparam logic [4:0] OP_RECAL     = 5'h07;
  localparam logic [4:0] OP_SENSE_INT = 5'h08;
  localparam logic [4:0] OP_SEEK      = 5'h0F;
  localparam logic [4:0] OP_CONFIG    = 5'h13;
  localparam logic [4:0] OP_VERSION   = 5'h18;

  localparam logic [7:0] ST0_INVALID  = 8'h80;
  localparam logic [7:0] VERSION_ID   = 8'h73;

  typedef struct packed {
    logic              known;
    logic [CIDX_W-1:0] cmd_len;
    logic [RIDX_W-1:0] res_len;
    logic              needs_exec;
    logic              sets_busy;
    logic              sense_int;
    logic              version;
  } cmd_info_t;
endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_seq_pkg::*;
(
  input  logic [4:0] opcode,
  input  logic       ext_track_en,
  output cmd_info_t  info
);
  always_comb begin
    info = '0;
    case (opcode)
      OP_SPECIFY: begin
        info.known   = 1'b1;
        info.cmd_len = CIDX_W'(3);
      end
      OP_SENSE_DRV: begin
        info.known      = 1'b1;
        info.cmd_len    = CIDX_W'(2);
        info.res_len    = RIDX_W'(1);
        info.needs_exec = 1'b1;
      end
      OP_READ: begin
        info.known      = 1'b1;
        info.cmd_len    = CIDX_W'(9);
        info.res_len    = RIDX_W'(7);
        info.needs_exec = 1'b1;
      end
      OP_RECAL: begin
        info.known     = 1'b1;
        info.cmd_len   = CIDX_W'(2);
        info.sets_busy = 1'b1;
      end
      OP_SENSE_INT: begin
        info.known     = 1'b1;
        info.cmd_len   = CIDX_W'(1);
        info.res_len   = ext_track_en ? RIDX_W'(3) : RIDX_W'(2);
        info.sense_int = 1'b1;
      end
      OP_SEEK: begin
        info.known     = 1'b1;
        info.cmd_len   = ext_track_en ? CIDX_W'(4) : CIDX_W'(3);
        info.sets_busy = 1'b1;
      end
      OP_CONFIG: begin
        info.known   = 1'b1;
        info.cmd_len = CIDX_W'(4);
      end
      OP_VERSION: begin
        info.known   = 1'b1;
        info.cmd_len = CIDX_W'(1);
        info.res_len = RIDX_W'(1);
        info.version = 1'b1;
      end
      default: info = '0;
    endcase
  end
endmodule

// File: rtl/fdc_cmd_buf.sv
module fdc_cmd_buf
  import fdc_seq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [CIDX_W-1:0]             wr_idx,
  input  logic [7:0]                    wr_data,
  output logic [KEEP_HI:KEEP_LO][7:0]   kept
);
  for (genvar i = KEEP_LO; i <= KEEP_HI; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                 kept[i] <= '0;
      else if (wr_en && wr_idx == CIDX_W'(i))     kept[i] <= wr_data;
    end

    assert_buf_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == CIDX_W'(i)) |=> kept[i] == $past(wr_data))
      else $error("command byte %0d not captured", i);
  end
endmodule

// File: rtl/fdc_drive_busy.sv
module fdc_drive_busy
  import fdc_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_en,
  input  logic [DRV_W-1:0]      set_drv,
  input  logic                  clr_en,
  input  logic [DRV_W-1:0]      clr_drv,
  output logic [NUM_DRIVES-1:0] busy
);
  for (genvar i = 0; i < NUM_DRIVES; i++) begin : g_drv
    always_ff @(posedge clk) begin
      if (!rst_n)                                  busy[i] <= 1'b0;
      else if (set_en && set_drv == DRV_W'(i))     busy[i] <= 1'b1;
      else if (clr_en && clr_drv == DRV_W'(i))     busy[i] <= 1'b0;
    end

    assert_busy_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[i]) |-> $past(set_en && set_drv == DRV_W'(i)))
      else $error("drive %0d busy set without seek", i);

    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[i]) |-> $past(clr_en && clr_drv == DRV_W'(i)))
      else $error("drive %0d busy cleared without sense", i);
  end
endmodule

// File: rtl/fdc_phase_seq.sv
module fdc_phase_seq
  import fdc_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_track_en,
  input  logic       nondma_mode,
  input  logic       host_wr_valid,
  output logic       host_wr_ready,
  input  logic [7:0] host_wr_data,
  output logic       host_rd_valid,
  input  logic       host_rd_ready,
  output logic [7:0] host_rd_data,
  output logic [7:0] msr,
  output logic       exec_start,
  output logic [4:0] exec_opcode,
  input  logic       exec_done,
  input  logic [7:0] exec_st0,
  input  logic [7:0] exec_st1,
  input  logic [7:0] exec_st2,
  input  logic [7:0] sense_st0,
  input  logic [7:0] sense_pcn,
  input  logic [7:0] sense_pcn_hi
);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);

  phase_t                     phase_q;
  logic                       gap_q;
  logic [INIT_W-1:0]          init_cnt_q;
  logic [CIDX_W-1:0]          widx_q;
  logic [RIDX_W-1:0]          ridx_q;
  logic [RIDX_W-1:0]          rlen_q;
  logic                       cb_q;
  logic                       sint_q;
  logic [4:0]                 op_q;
  logic                       exec_start_q;
  logic [RES_SLOTS-1:0][7:0]  res_q;

  logic                       rqm, dio, ndma;
  logic                       wr_fire, rd_fire, last_byte;
  logic [4:0]                 dec_op;
  cmd_info_t                  info;
  logic [KEEP_HI:KEEP_LO][7:0] kept;
  logic [NUM_DRIVES-1:0]      busy;
  logic [7:0]                 drv_byte;

  // handshake and status
  assign rqm           = (phase_q == PH_CMD || phase_q == PH_RES) && !gap_q;
  assign dio           = (phase_q == PH_RES);
  assign ndma          = (phase_q == PH_EXEC) && nondma_mode;
  assign host_wr_ready = rqm && !dio;
  assign host_rd_valid = rqm && dio;
  assign wr_fire       = host_wr_valid && host_wr_ready;
  assign rd_fire       = host_rd_valid && host_rd_ready;
  assign host_rd_data  = res_q[ridx_q];
  assign msr           = {rqm, dio, ndma, cb_q, busy};
  assign exec_start    = exec_start_q;
  assign exec_opcode   = op_q;

  // decode the byte on the bus for the opcode, the latched opcode afterwards
  assign dec_op = (phase_q == PH_CMD && widx_q == '0) ? host_wr_data[4:0] : op_q;

  fdc_cmd_decode u_dec (
    .opcode       (dec_op),
    .ext_track_en (ext_track_en),
    .info         (info)
  );

  assign last_byte = wr_fire && info.known && (widx_q == info.cmd_len - CIDX_W'(1));

  fdc_cmd_buf u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .wr_idx  (widx_q),
    .wr_data (host_wr_data),
    .kept    (kept)
  );

  assign drv_byte = (widx_q == CIDX_W'(1)) ? host_wr_data : kept[1];

  fdc_drive_busy u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (last_byte && info.sets_busy),
    .set_drv (drv_byte[DRV_W-1:0]),
    .clr_en  (rd_fire && sint_q && ridx_q == '0),
    .clr_drv (res_q[0][DRV_W-1:0]),
    .busy    (busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q      <= PH_INIT;
      gap_q        <= 1'b0;
      init_cnt_q   <= '0;
      widx_q       <= '0;
      ridx_q       <= '0;
      rlen_q       <= '0;
      cb_q         <= 1'b0;
      sint_q       <= 1'b0;
      op_q         <= '0;
      exec_start_q <= 1'b0;
      res_q        <= '0;
    end else begin
      exec_start_q <= 1'b0;
      gap_q        <= wr_fire || rd_fire;
      case (phase_q)
        PH_INIT: begin
          if (init_cnt_q == INIT_W'(INIT_CYCLES - 1)) phase_q <= PH_CMD;
          else                                        init_cnt_q <= init_cnt_q + 1'b1;
        end
        PH_CMD: begin
          if (wr_fire) begin
            cb_q <= 1'b1;
            if (widx_q == '0) begin
              op_q   <= host_wr_data[4:0];
              sint_q <= info.sense_int;
            end
            if (!info.known) begin
              res_q[0] <= ST0_INVALID;
              rlen_q   <= RIDX_W'(1);
              ridx_q   <= '0;
              widx_q   <= '0;
              sint_q   <= 1'b0;
              phase_q  <= PH_RES;
            end else if (last_byte) begin
              widx_q <= '0;
              if (info.needs_exec) begin
                phase_q      <= PH_EXEC;
                exec_start_q <= 1'b1;
              end else if (info.res_len != '0) begin
                phase_q <= PH_RES;
                rlen_q  <= info.res_len;
                ridx_q  <= '0;
                if (info.version) res_q[0] <= VERSION_ID;
                if (info.sense_int) begin
                  res_q[0] <= sense_st0;
                  res_q[1] <= sense_pcn;
                  res_q[2] <= sense_pcn_hi;
                end
              end else begin
                cb_q <= 1'b0;
              end
            end else begin
              widx_q <= widx_q + 1'b1;
            end
          end
        end
        PH_EXEC: begin
          if (exec_done) begin
            res_q[0] <= exec_st0;
            res_q[1] <= exec_st1;
            res_q[2] <= exec_st2;
            for (int k = 2; k <= KEEP_HI; k++) res_q[k + 1] <= kept[k];
            rlen_q  <= info.res_len;
            ridx_q  <= '0;
            phase_q <= PH_RES;
          end
        end
        PH_RES: begin
          if (rd_fire) begin
            if (ridx_q == rlen_q - RIDX_W'(1)) begin
              phase_q <= PH_CMD;
              cb_q    <= 1'b0;
              sint_q  <= 1'b0;
              ridx_q  <= '0;
            end else begin
              ridx_q <= ridx_q + 1'b1;
            end
          end
        end
        default: phase_q <= PH_INIT;
      endcase
    end
  end

  assert_init_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INIT) |-> (msr == 8'h00 && !host_wr_ready && !host_rd_valid))
    else $error("status not quiet during init");

  assert_gap_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !msr[7])
    else $error("request-for-master stayed high after write");

  assert_gap_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !msr[7])
    else $error("request-for-master stayed high after read");

  assert_busy_on_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && widx_q == '0) |=> msr[4])
    else $error("command busy not set by opcode");

  assert_invalid_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && widx_q == '0 && !info.known) |=> (msr[6] && host_rd_data == ST0_INVALID))
    else $error("invalid opcode not answered with 80h");

  assert_version_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && widx_q == '0 && host_wr_data[4:0] == OP_VERSION) |=> host_rd_data == VERSION_ID)
    else $error("version answer wrong");

  assert_exec_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> (msr[7:6] == 2'b00 && $past(wr_fire)))
    else $error("exec start outside command end");

  assert_ignore_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_valid && msr[6]) |=> ($stable(op_q) && $stable(widx_q)))
    else $error("write during result phase changed state");
endmodule

// File: tb/fdc_phase_seq_test.sv
module fdc_phase_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int INIT       = 64;
  localparam int WATCHDOG   = 100000;
  localparam int NV         = 12;

  localparam logic        V_EXT  [NV] = '{0,0,0,0,0,0,0,0,1,0,1,0};
  localparam int          V_NCMD [NV] = '{1,1,1,1,3,4,2,9,4,1,1,2};
  localparam logic [71:0] V_CMD  [NV] = '{
    72'h18, 72'hD8, 72'h1F, 72'h00, 72'h02_AF_03, 72'h00_57_00_13, 72'h01_04,
    72'hFF_1B_12_02_03_00_0A_01_66, 72'h02_10_01_0F, 72'h08, 72'h08, 72'h03_07};
  localparam int          V_NRES [NV] = '{1,1,1,1,0,0,1,7,0,2,3,0};
  localparam logic [55:0] V_RES  [NV] = '{
    56'h73, 56'h73, 56'h80, 56'h80, 56'h0, 56'h0, 56'h41,
    56'h02_03_00_0A_02_05_41, 56'h0, 56'h4C_21, 56'h03_4C_21, 56'h0};
  localparam logic [7:0]  V_MSR  [NV] = '{8'h80,8'h80,8'h80,8'h80,8'h80,8'h80,
                                          8'h80,8'h80,8'h82,8'h80,8'h80,8'h88};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_track_en = 1'b0, nondma_mode = 1'b0;
  logic host_wr_valid = 1'b0, host_rd_ready = 1'b0, exec_done = 1'b0;
  logic [7:0] host_wr_data = '0;
  logic [7:0] exec_st0 = 8'h41, exec_st1 = 8'h05, exec_st2 = 8'h02;
  logic [7:0] sense_st0 = 8'h21, sense_pcn = 8'h4C, sense_pcn_hi = 8'h03;
  logic host_wr_ready, host_rd_valid, exec_start;
  logic [7:0] host_rd_data, msr;
  logic [4:0] exec_opcode;

  int n_checks = 0, n_fail = 0;

  fdc_phase_seq #(.INIT_CYCLES(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .ext_track_en(ext_track_en), .nondma_mode(nondma_mode),
    .host_wr_valid(host_wr_valid), .host_wr_ready(host_wr_ready), .host_wr_data(host_wr_data),
    .host_rd_valid(host_rd_valid), .host_rd_ready(host_rd_ready), .host_rd_data(host_rd_data),
    .msr(msr), .exec_start(exec_start), .exec_opcode(exec_opcode), .exec_done(exec_done),
    .exec_st0(exec_st0), .exec_st1(exec_st1), .exec_st2(exec_st2),
    .sense_st0(sense_st0), .sense_pcn(sense_pcn), .sense_pcn_hi(sense_pcn_hi));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] b);
    do @(negedge clk); while (!host_wr_ready);
    host_wr_data  = b;
    host_wr_valid = 1'b1;
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  task automatic host_read(output logic [7:0] b);
    do @(negedge clk); while (!host_rd_valid);
    b = host_rd_data;
    host_rd_ready = 1'b1;
    @(negedge clk);
    host_rd_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // execution engine stub
  initial begin
    forever begin
      @(negedge clk);
      if (exec_start) begin
        repeat (3) @(negedge clk);
        exec_done = 1'b1;
        @(negedge clk);
        exec_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    // R1: power-up window
    do_reset();
    check("R1 at release", msr, 8'h00);
    repeat (INIT - 1) @(negedge clk);
    check("R1 last init cycle", msr, 8'h00);
    check("R1 no ready in init", {7'd0, host_wr_ready}, 8'h00);
    @(negedge clk);
    check("R1 ready", msr, 8'h80);

    // table: R5 lengths, R6 extended option, R7 invalid, R8 version, R10/R11 results
    for (int v = 0; v < NV; v++) begin
      ext_track_en = V_EXT[v];
      for (int i = 0; i < V_NCMD[v]; i++) host_write(V_CMD[v][8*i +: 8]);
      for (int j = 0; j < V_NRES[v]; j++) begin
        host_read(b);
        check(V_EXT[v] ? "R6 result byte" : "R5 result byte", b, V_RES[v][8*j +: 8]);
      end
      @(negedge clk);
      check(V_EXT[v] ? "R6 status after" : "R5 status after", msr, V_MSR[v]);
    end
    ext_track_en = 1'b0;

    do_reset();
    repeat (INIT + 1) @(negedge clk);

    // R2/R4: byte gap and command busy during a 3-byte seek to drive 2
    host_write(8'h0F);
    check("R2 gap after write", msr, 8'h10);
    @(negedge clk);
    check("R4 busy with rqm", msr, 8'h90);
    host_write(8'h02);
    check("R2 gap second byte", msr, 8'h10);
    host_write(8'h05);
    check("R9 busy set, R4 cleared", msr, 8'h04);
    @(negedge clk);
    check("R4 idle with drive busy", msr, 8'h84);

    // R3/R10: execution phase flags
    nondma_mode = 1'b1;
    host_write(8'h04);
    host_write(8'h00);
    check("R3 exec status layout", msr, 8'h34);
    check("R10 exec start", {7'd0, exec_start}, 8'h01);
    check("R10 exec opcode", {3'd0, exec_opcode}, 8'h04);
    host_read(b);
    check("R10 exec result", b, 8'h41);
    nondma_mode = 1'b0;
    @(negedge clk);
    check("R4 after exec result", msr, 8'h84);

    // R12: wrong-direction attempts ignored
    host_write(8'h18);
    @(negedge clk);
    check("R12 result ready", msr, 8'hD4);
    host_wr_data = 8'h0F; host_wr_valid = 1'b1;
    repeat (4) @(negedge clk);
    host_wr_valid = 1'b0;
    check("R12 write in result phase", msr, 8'hD4);
    host_read(b);
    check("R12 result intact", b, 8'h73);
    @(negedge clk);
    host_rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    host_rd_ready = 1'b0;
    check("R12 read in command phase", msr, 8'h84);
    exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0;
    @(negedge clk);
    check("R12 stray exec_done", msr, 8'h84);

    // R9/R11: sense interrupt clears drive 2
    sense_st0 = 8'h22;
    host_write(8'h08);
    check("R11 gap into result", msr, 8'h54);
    host_read(b);
    check("R11 st0 byte", b, 8'h22);
    check("R9 busy cleared on first read", msr, 8'h50);
    host_read(b);
    check("R11 track byte", b, 8'h4C);
    @(negedge clk);
    check("R9 idle clean", msr, 8'h80);

    // R7: unknown opcode with modifier bits
    host_write(8'hE1);
    check("R7 straight to result", msr, 8'h50);
    host_read(b);
    check("R7 invalid byte", b, 8'h80);
    @(negedge clk);
    check("R7 back to idle", msr, 8'h80);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule